// File: doc/BRIEF.md
# Addressed Two-Frame Output Latch

This block sits behind a serial frame receiver on a line shared by up to eight listeners. Each received frame brings a 3-bit address and a 4-bit nibble. Two frames in a row that both carry this listener's address, taken from three strap inputs, form one byte. The first frame supplies the low nibble and the second supplies the high nibble. When a pair is accepted, the byte is loaded into an 8-bit output register. The load happens half a measured bit period after the second frame is reported. At the same moment an active-low acknowledge output drops for one measured bit period.

The stored byte reaches eight pad outputs through a mode stage. In open-collector mode the stage drives the inverse of each stored bit. In push-pull mode it drives the stored bit directly. A separate enable input places all eight pads in high impedance, which is shown by their drive-enable outputs going low.

If the second frame carries a different address, or the receiver reports a framing error, the partial pair is discarded and the register is left as it was.

Top module: `addr_pair_latch`

## Requirements
- R1: After reset the output register holds 0x00 and `ack_n` is high.
- R2: In an accepted pair, the nibble of the first frame becomes register bits 3..0 and the nibble of the second frame becomes bits 7..4.
- R3: A frame whose address differs from `strap_addr` does not start a pair and is otherwise ignored.
- R4: If the second frame's address differs from the first frame's address, the pair is dropped. The register and `ack_n` do not change, and the next frame is treated as a first frame.
- R5: A cycle with `frm_err` high discards any held first frame. The next valid frame is treated as a first frame.
- R6: Let P be `bit_period` (at least 2) and let E0 be the clock edge that samples the accepting second frame. The register takes its new value at edge E0 + P/2, using integer division. It holds the old value before that edge.
- R7: `ack_n` goes low at the same edge as the register update and stays low for exactly P clock cycles. It goes low only when a pair has been accepted.
- R8: With `oc_mode` = 1, `pad_o` is the bitwise inverse of the register. With `oc_mode` = 0, `pad_o` equals the register.
- R9: With `out_en` = 0, all eight bits of `pad_oe` are 0, meaning high impedance, in either mode. With `out_en` = 1, all eight bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe: a decoded frame is present |
| frm_err | input | 1 | Framing error reported by the receiver |
| frm_addr | input | 3 | Address field of the frame |
| frm_nib | input | 4 | Data nibble of the frame |
| bit_period | input | 16 | Measured bit period in clock cycles |
| strap_addr | input | 3 | This listener's address |
| oc_mode | input | 1 | 1 = open-collector (inverted), 0 = push-pull |
| out_en | input | 1 | 1 = pads driven, 0 = high impedance |
| pad_o | output | 8 | Level driven onto each pad |
| pad_oe | output | 8 | Per-pad drive enable |
| ack_n | output | 1 | Active-low acknowledge pulse |

## Verification
A directed pair carrying 0xA5 shows whether the nibbles land in the right halves of the register. A pair whose address changes between frames, a first frame for another listener, and a framing error placed between frames each check that the register stays put and that the next frame opens a new pair. A long stream of random frames follows. In it the address mostly matches, errors are sparse and the bit period varies from 2 to 40 cycles, which tests the update delay and the acknowledge length against the integer halving, including the smallest period. Output mode and enable are toggled while the register holds known values, so the inversion and the high-impedance state can be told apart from a wrong stored value.

// File: rtl/apl_pkg.sv
package apl_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned DATA_W = 2 * NIB_W;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned PER_W  = 16;

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PER_W-1:0]  per_t;
endpackage

// File: rtl/apl_pair_assembler.sv
module apl_pair_assembler
  import apl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frm_valid,
  input  logic  frm_err,
  input  addr_t frm_addr,
  input  nib_t  frm_nib,
  input  addr_t strap_addr,
  output logic  launch,
  output byte_t launch_byte
);
  logic  held_q, held_d;
  addr_t haddr_q, haddr_d;
  nib_t  hnib_q, hnib_d;
  logic  good_frame;

  assign good_frame  = frm_valid && !frm_err;
  assign launch      = good_frame && held_q && (frm_addr == haddr_q);
  assign launch_byte = {frm_nib, hnib_q};

  always_comb begin
    held_d  = held_q;
    haddr_d = haddr_q;
    hnib_d  = hnib_q;
    if (frm_err) begin
      held_d = 1'b0;
    end else if (frm_valid) begin
      if (held_q) begin
        held_d = 1'b0;
      end else if (frm_addr == strap_addr) begin
        held_d  = 1'b1;
        haddr_d = frm_addr;
        hnib_d  = frm_nib;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      haddr_q <= '0;
      hnib_q  <= '0;
    end else begin
      held_q  <= held_d;
      haddr_q <= haddr_d;
      hnib_q  <= hnib_d;
    end
  end

  // R5: an error never leaves a first frame held
  p_err_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err |=> !held_q);
  // R3: a pair can only complete on this listener's address
  p_launch_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> held_q && (haddr_q == frm_addr));
endmodule

// File: rtl/apl_commit_timer.sv
module apl_commit_timer
  import apl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  launch,
  input  byte_t launch_byte,
  input  per_t  bit_period,
  output byte_t data_q,
  output logic  ack_n
);
  per_t  dly_q, dly_d;
  per_t  per_q, per_d;
  per_t  ack_q, ack_d;
  byte_t pend_q, pend_d;
  byte_t data_d;
  per_t  half;

  assign half  = ((bit_period >> 1) == '0) ? per_t'(1) : (bit_period >> 1);
  assign ack_n = (ack_q == '0);

  always_comb begin
    dly_d  = dly_q;
    per_d  = per_q;
    pend_d = pend_q;
    data_d = data_q;
    ack_d  = ack_q;
    if (ack_q != '0) ack_d = ack_q - 1'b1;
    if (launch) begin
      dly_d  = half;
      per_d  = bit_period;
      pend_d = launch_byte;
    end else if (dly_q != '0) begin
      dly_d = dly_q - 1'b1;
      if (dly_q == per_t'(1)) begin
        data_d = pend_q;
        ack_d  = per_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= '0;
      per_q  <= '0;
      pend_q <= '0;
      data_q <= '0;
      ack_q  <= '0;
    end else begin
      dly_q  <= dly_d;
      per_q  <= per_d;
      pend_q <= pend_d;
      data_q <= data_d;
      ack_q  <= ack_d;
    end
  end

  // R6: the register moves only when the delay expires
  p_update_on_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> $past(dly_q) == per_t'(1));
  // R7: acknowledge starts only on a commit
  p_ack_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(dly_q) == per_t'(1));
  // R7: acknowledge ends only after its count is used up
  p_ack_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> $past(ack_q) == per_t'(1));
endmodule

// File: rtl/apl_pad_stage.sv
module apl_pad_stage
  import apl_pkg::*;
(
  input  byte_t data_q,
  input  logic  oc_mode,
  input  logic  out_en,
  output byte_t pad_o,
  output byte_t pad_oe
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_pad
    assign pad_o[i]  = oc_mode ? ~data_q[i] : data_q[i];
    assign pad_oe[i] = out_en;
  end

  // R9: enables move together
  always_comb begin
    a_oe_uniform_r9: assert ((pad_oe == '0) || (pad_oe == '1));
  end
endmodule

// File: rtl/addr_pair_latch.sv
module addr_pair_latch
  import apl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic              frm_err,
  input  logic [ADDR_W-1:0] frm_addr,
  input  logic [NIB_W-1:0]  frm_nib,
  input  logic [PER_W-1:0]  bit_period,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              oc_mode,
  input  logic              out_en,
  output logic [DATA_W-1:0] pad_o,
  output logic [DATA_W-1:0] pad_oe,
  output logic              ack_n
);
  logic  launch;
  byte_t launch_byte;
  byte_t data_q;

  apl_pair_assembler u_asm (
    .clk, .rst_n, .frm_valid, .frm_err, .frm_addr, .frm_nib, .strap_addr,
    .launch, .launch_byte
  );

  apl_commit_timer u_tmr (
    .clk, .rst_n, .launch, .launch_byte, .bit_period, .data_q, .ack_n
  );

  apl_pad_stage u_pad (
    .data_q, .oc_mode, .out_en, .pad_o, .pad_oe
  );
endmodule

// File: tb/addr_pair_latch_test.sv
module addr_pair_latch_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] STRAP = 3'd5;

  logic clk = 1'b0;
  logic rst_n, frm_valid, frm_err, oc_mode, out_en, ack_n;
  logic [2:0] frm_addr;
  logic [3:0] frm_nib;
  logic [15:0] bit_period;
  logic [7:0] pad_o, pad_oe;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;
  logic mdl_held; logic [2:0] mdl_haddr; logic [3:0] mdl_hnib; logic [7:0] mdl_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_pair_latch uut (
    .clk, .rst_n, .frm_valid, .frm_err, .frm_addr, .frm_nib, .bit_period,
    .strap_addr(STRAP), .oc_mode, .out_en, .pad_o, .pad_oe, .ack_n
  );

  function automatic logic [7:0] exp_pad(logic [7:0] d, logic oc);
    return oc ? ~d : d;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // Drive one frame and check the outcome against the bench model
  task automatic send(logic [2:0] a, logic [3:0] n, logic e, int p);
    bit launch_exp;
    int h, low;
    bit bad;
    logic [7:0] old;
    @(negedge clk);
    frm_valid = 1'b1; frm_err = e; frm_addr = a; frm_nib = n;
    bit_period = 16'(p);
    launch_exp = !e && mdl_held && (a == mdl_haddr);
    old = mdl_data;
    if (e) mdl_held = 1'b0;
    else if (mdl_held) begin
      mdl_held = 1'b0;
      if (launch_exp) mdl_data = {n, mdl_hnib};
    end else if (a == STRAP) begin
      mdl_held = 1'b1; mdl_haddr = a; mdl_hnib = n;
    end
    @(posedge clk);
    @(negedge clk);
    frm_valid = 1'b0; frm_err = 1'b0;
    h = p / 2;
    if (launch_exp) begin
      bad = 0;
      for (int k = 1; k < h; k++) begin
        @(posedge clk); @(negedge clk);
        if (pad_o != exp_pad(old, oc_mode) || !ack_n) bad = 1;
      end
      chk(!bad, "R6 hold before update", int'(pad_o), int'(exp_pad(old, oc_mode)));
      @(posedge clk); @(negedge clk);
      chk(pad_o == exp_pad(mdl_data, oc_mode), "R2/R6 value at update",
          int'(pad_o), int'(exp_pad(mdl_data, oc_mode)));
      low = ack_n ? 0 : 1;
      for (int k = 0; k < 200 && !ack_n; k++) begin
        @(negedge clk);
        if (!ack_n) low++;
      end
      chk(low == p, "R7 ack length", low, p);
    end else begin
      bad = 0;
      for (int k = 0; k < h + p + 3; k++) begin
        @(negedge clk);
        if (!ack_n || pad_o != exp_pad(old, oc_mode)) bad = 1;
      end
      chk(!bad, "R4 no update without accepted pair", int'(pad_o),
          int'(exp_pad(old, oc_mode)));
    end
  endtask

  initial begin
    rst_n = 1'b0; frm_valid = 1'b0; frm_err = 1'b0; frm_addr = '0; frm_nib = '0;
    bit_period = 16'd4; oc_mode = 1'b0; out_en = 1'b1;
    mdl_held = 0; mdl_haddr = '0; mdl_hnib = '0; mdl_data = '0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pad_o == 8'h00 && ack_n, "R1 reset state", int'({ack_n, pad_o}), 'h100);

    // R2 nibble order
    send(STRAP, 4'h5, 1'b0, 6);
    send(STRAP, 4'hA, 1'b0, 6);
    chk(pad_o == 8'hA5, "R2 byte assembled", int'(pad_o), 'hA5);
    // R8 inversion
    @(negedge clk); oc_mode = 1'b1; #1;
    chk(pad_o == 8'h5A, "R8 open-collector inverts", int'(pad_o), 'h5A);
    // R9 high impedance in both modes
    out_en = 1'b0; #1;
    chk(pad_oe == 8'h00, "R9 disabled oc", int'(pad_oe), 0);
    oc_mode = 1'b0; #1;
    chk(pad_oe == 8'h00, "R9 disabled pp", int'(pad_oe), 0);
    out_en = 1'b1; #1;
    chk(pad_oe == 8'hFF && pad_o == 8'hA5, "R9 enabled", int'(pad_oe), 'hFF);
    // R4 mismatch then fresh pair
    send(STRAP, 4'h1, 1'b0, 8);
    send(3'd2, 4'h2, 1'b0, 8);
    send(STRAP, 4'h3, 1'b0, 8);
    send(STRAP, 4'h4, 1'b0, 8);
    chk(pad_o == 8'h43, "R4 next frame starts pair", int'(pad_o), 'h43);
    // R3 foreign first frame ignored
    send(3'd1, 4'h7, 1'b0, 4);
    send(STRAP, 4'h8, 1'b0, 4);
    send(STRAP, 4'h9, 1'b0, 4);
    chk(pad_o == 8'h98, "R3 foreign frame ignored", int'(pad_o), 'h98);
    // R5 framing error between frames
    send(STRAP, 4'hC, 1'b0, 5);
    send(STRAP, 4'hD, 1'b1, 5);
    send(STRAP, 4'hE, 1'b0, 5);
    send(STRAP, 4'hF, 1'b0, 5);
    chk(pad_o == 8'hFE, "R5 error discards half pair", int'(pad_o), 'hFE);
    // R6/R7 smallest period
    send(STRAP, 4'h2, 1'b0, 2);
    send(STRAP, 4'h6, 1'b0, 2);

    for (int i = 0; i < 300; i++) begin
      logic [2:0] a;
      logic e;
      a = ($urandom % 4 != 0) ? STRAP : 3'($urandom);
      e = ($urandom % 10 == 0);
      @(negedge clk); oc_mode = 1'($urandom);
      send(a, 4'($urandom), e, 2 + int'($urandom % 39));
    end
    done = 1;
    finish_run();
  end
endmodule